// File: doc/BRIEF.md
# Quad I/O Flash Read Responder

This block is the device side of a serial flash that answers only the quad I/O read command. It runs entirely on the serial clock. Chip select low starts a transaction and chip select high clears it at once. The opcode comes in one bit per clock on line 0 in single-line mode. In four-line command mode it comes four bits per clock. The block then takes a 24-bit address over all four lines and waits a fixed number of dummy clocks. After that it streams bytes from a small on-chip array, one nibble per clock, until the host raises chip select.

The pads are split at the core boundary into an input bus, an output bus and a per-line output enable. Rising clock edges sample inputs. Falling clock edges launch output nibbles. The command is refused when the quad-enable bit is clear, when a write cycle is busy, or when the opcode is wrong. A refused command leaves every output disabled for the rest of the selection.

Top module: `qspi_rd_resp`

## Requirements
- R1: While `cs_n` is high, `sio_oe` is 4'h0, and the next selection begins with a fresh opcode phase.
- R2: With `qpi_mode`=0 the opcode is taken MSB first from `sio_i[0]` on 8 rising edges, and `sio_i[3:1]` are ignored.
- R3: With `qpi_mode`=1 the opcode is taken on 2 rising edges as nibbles, high nibble first, with `sio_i[3]` as the nibble MSB.
- R4: An opcode other than 8'hEB is refused: `sio_oe` stays 4'h0 until `cs_n` rises.
- R5: If `quad_en` is 0 on the final opcode edge, the command is refused and `sio_oe` stays 4'h0 until `cs_n` rises.
- R6: If `wr_busy` is 1 on the final opcode edge, the command is refused and `sio_oe` stays 4'h0 until `cs_n` rises.
- R7: The address is 24 bits on 6 rising edges, high nibble first, with `sio_i[3]` as the nibble MSB. Only the low `ADDR_W` bits (default 8) select a byte.
- R8: After the address come `DUMMY` rising edges (default 6). `sio_oe` is 4'h0 through the opcode, address and dummy phases.
- R9: The first nibble is driven on the falling edge that follows the last dummy rising edge. A new nibble follows on every falling edge, high nibble of each byte first, with `sio_o[3]` as the nibble MSB. `sio_oe` is then 4'hF.
- R10: The byte at array address a is ((a[7:0]*29 + 3) mod 256) XOR a[15:8], where a is the array index zero-extended to 24 bits.
- R11: The address advances by one after each full byte and wraps from 2^ADDR_W-1 to 0, so one command can stream the whole array.
- R12: Raising `cs_n` during data output disables `sio_oe` without waiting for a clock edge. The next command then runs normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; high clears the transaction asynchronously |
| sio_i | input | 4 | Input side of the four data pads |
| quad_en | input | 1 | Quad-enable status bit |
| qpi_mode | input | 1 | 1: opcode on four lines; 0: opcode on line 0 |
| wr_busy | input | 1 | A program, erase or status-write cycle is running |
| sio_o | output | 4 | Output side of the four data pads |
| sio_oe | output | 4 | Per-pad output enable |

## Verification
Two functions can fall on the same rising edge. One is the byte-address increment after a low nibble. The other is the wrap from the top of the array back to zero. Commands that start at 0xFE, and one stream that runs past the top of the array, provoke this collision. The nibbles that follow are judged against the content formula at the wrapped address. The final opcode edge is a second collision point: the opcode check, the quad-enable check and the busy check are all decided there. Commands that differ in only one of these inputs must show either a full data stream or outputs that stay disabled.

// File: rtl/qspi_rd_pkg.sv
`timescale 1ns/1ps
package qspi_rd_pkg;

    typedef enum logic [2:0] {
        PH_OPC    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_DUMMY  = 3'd2,
        PH_DATA   = 3'd3,
        PH_REJECT = 3'd4
    } phase_e;

    localparam logic [7:0] OPC_QUAD_READ = 8'hEB;
    localparam int unsigned ADDR_BITS_BUS = 24;

    // Content generator for the array: low byte scrambled, XOR middle byte.
    function automatic logic [7:0] cell_value(input logic [23:0] a);
        logic [7:0] lo;
        lo = a[7:0];
        return (lo * 8'd29 + 8'd3) ^ a[15:8];
    endfunction

endpackage

// File: rtl/qspi_rd_rom.sv
`timescale 1ns/1ps
module qspi_rd_rom
    import qspi_rd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] idx,
    output logic [7:0]        dout
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = cell_value(24'(i));
    end

    assign dout = cells[idx];

endmodule

// File: rtl/qspi_rd_fsm.sv
`timescale 1ns/1ps
module qspi_rd_fsm
    import qspi_rd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DUMMY  = 6   // must be at least 1
) (
    input  logic              sclk,
    input  logic              cs_n,
    input  logic [3:0]        sio_i,
    input  logic              quad_en,
    input  logic              qpi_mode,
    input  logic              wr_busy,
    output phase_e            phase,
    output logic [ADDR_W-1:0] addr,
    output logic              nib_lo
);
    localparam int CNT_MAX = (DUMMY > 8) ? DUMMY : 8;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int ADDR_NIBBLES = ADDR_BITS_BUS / 4;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        op;
        logic [ADDR_W-1:0] addr;
        logic              lo;
    } st_t;

    localparam st_t ST_RESET = '{ph: PH_OPC, default: '0};

    st_t        st_d, st_q;
    logic [7:0] op_nx;
    logic       op_last;

    always_comb begin
        st_d    = st_q;
        op_nx   = st_q.op;
        op_last = 1'b0;
        unique case (st_q.ph)
            PH_OPC: begin
                if (qpi_mode) begin
                    op_nx   = {st_q.op[3:0], sio_i};
                    op_last = (st_q.cnt == CNT_W'(1));
                end else begin
                    op_nx   = {st_q.op[6:0], sio_i[0]};
                    op_last = (st_q.cnt == CNT_W'(7));
                end
                st_d.op  = op_nx;
                st_d.cnt = st_q.cnt + 1'b1;
                if (op_last) begin
                    st_d.cnt = '0;
                    st_d.ph  = (op_nx == OPC_QUAD_READ && quad_en && !wr_busy)
                               ? PH_ADDR : PH_REJECT;
                end
            end
            PH_ADDR: begin
                st_d.addr = ADDR_W'({st_q.addr, sio_i});
                st_d.cnt  = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(ADDR_NIBBLES - 1)) begin
                    st_d.cnt = '0;
                    st_d.ph  = PH_DUMMY;
                end
            end
            PH_DUMMY: begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_W'(DUMMY - 1)) begin
                    st_d.cnt = '0;
                    st_d.lo  = 1'b0;
                    st_d.ph  = PH_DATA;
                end
            end
            PH_DATA: begin
                st_d.lo = ~st_q.lo;
                if (st_q.lo) begin
                    st_d.addr = st_q.addr + 1'b1;
                end
            end
            PH_REJECT: st_d = st_q;
            default:   st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge sclk or posedge cs_n) begin
        if (cs_n) st_q <= ST_RESET;
        else      st_q <= st_d;
    end

    assign phase  = st_q.ph;
    assign addr   = st_q.addr;
    assign nib_lo = st_q.lo;

    AST_REJECT_HOLDS: assert property (@(posedge sclk) disable iff (cs_n)
        st_q.ph == PH_REJECT |=> st_q.ph == PH_REJECT); // R4

    AST_NO_START_WITHOUT_QE: assert property (@(posedge sclk) disable iff (cs_n)
        (st_q.ph == PH_OPC && !quad_en) |=> st_q.ph != PH_ADDR); // R5

    AST_NO_START_WHEN_BUSY: assert property (@(posedge sclk) disable iff (cs_n)
        (st_q.ph == PH_OPC && wr_busy) |=> st_q.ph != PH_ADDR); // R6

    AST_ADDR_STEP: assert property (@(posedge sclk) disable iff (cs_n)
        (st_q.ph == PH_DATA && st_q.lo) |=> st_q.addr == $past(st_q.addr) + 1'b1); // R11

    AST_DATA_FROM_DUMMY: assert property (@(posedge sclk) disable iff (cs_n)
        $rose(st_q.ph == PH_DATA) |-> $past(st_q.ph) == PH_DUMMY); // R8

endmodule

// File: rtl/qspi_rd_drv.sv
`timescale 1ns/1ps
module qspi_rd_drv
    import qspi_rd_pkg::*;
(
    input  logic       sclk,
    input  logic       cs_n,
    input  phase_e     phase,
    input  logic       nib_lo,
    input  logic [7:0] byte_val,
    output logic [3:0] sio_o,
    output logic [3:0] sio_oe
);
    typedef struct packed {
        logic [3:0] dat;
        logic       en;
    } drv_t;

    drv_t dv_d, dv_q;

    always_comb begin
        dv_d.en  = (phase == PH_DATA);
        dv_d.dat = nib_lo ? byte_val[3:0] : byte_val[7:4];
    end

    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) dv_q <= '0;
        else      dv_q <= dv_d;
    end

    assign sio_o  = dv_q.dat;
    assign sio_oe = {4{dv_q.en}};

    AST_OE_DATA_ONLY: assert property (@(posedge sclk) disable iff (cs_n)
        (|sio_oe) |-> phase == PH_DATA); // R8

    AST_OE_ALL_OR_NONE: assert property (@(posedge sclk) disable iff (cs_n)
        (sio_oe == 4'h0) || (sio_oe == 4'hF)); // R9

    AST_NO_DRIVE_AFTER_REJECT: assert property (@(posedge sclk) disable iff (cs_n)
        phase == PH_REJECT |-> sio_oe == 4'h0); // R4

endmodule

// File: rtl/qspi_rd_resp.sv
`timescale 1ns/1ps
module qspi_rd_resp
    import qspi_rd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DUMMY  = 6
) (
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [3:0] sio_i,
    input  logic       quad_en,
    input  logic       qpi_mode,
    input  logic       wr_busy,
    output logic [3:0] sio_o,
    output logic [3:0] sio_oe
);
    phase_e            phase;
    logic [ADDR_W-1:0] addr;
    logic              nib_lo;
    logic [7:0]        byte_val;

    qspi_rd_fsm #(.ADDR_W(ADDR_W), .DUMMY(DUMMY)) u_fsm (
        .sclk     (sclk),
        .cs_n     (cs_n),
        .sio_i    (sio_i),
        .quad_en  (quad_en),
        .qpi_mode (qpi_mode),
        .wr_busy  (wr_busy),
        .phase    (phase),
        .addr     (addr),
        .nib_lo   (nib_lo)
    );

    qspi_rd_rom #(.ADDR_W(ADDR_W)) u_rom (
        .idx  (addr),
        .dout (byte_val)
    );

    qspi_rd_drv u_drv (
        .sclk     (sclk),
        .cs_n     (cs_n),
        .phase    (phase),
        .nib_lo   (nib_lo),
        .byte_val (byte_val),
        .sio_o    (sio_o),
        .sio_oe   (sio_oe)
    );

endmodule

// File: tb/qspi_rd_resp_tb.sv
`timescale 1ns/1ps
module qspi_rd_resp_tb;

    localparam int AW  = 8;
    localparam int DMY = 6;

    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic [3:0] sio_i = 4'h0;
    logic       quad_en = 1'b0;
    logic       qpi_mode = 1'b0;
    logic       wr_busy = 1'b0;
    logic [3:0] sio_o;
    logic [3:0] sio_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 sclk = ~sclk;  // 250 MHz

    qspi_rd_resp #(.ADDR_W(AW), .DUMMY(DMY)) u_dut (
        .sclk(sclk), .cs_n(cs_n), .sio_i(sio_i), .quad_en(quad_en),
        .qpi_mode(qpi_mode), .wr_busy(wr_busy), .sio_o(sio_o), .sio_oe(sio_oe)
    );

    typedef struct packed {
        logic        qpi;
        logic        qe;
        logic        busy;
        logic [7:0]  op;
        logic [23:0] addr;
        logic [9:0]  nbytes;
        logic        acc;
        logic [4:0]  tag;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 8'hEB, 24'h000010, 10'd4, 1'b1, 5'd2},  // R2 R9 R10
        '{1'b1, 1'b1, 1'b0, 8'hEB, 24'h0000FE, 10'd4, 1'b1, 5'd3},  // R3 R11 wrap
        '{1'b0, 1'b0, 1'b0, 8'hEB, 24'h000020, 10'd3, 1'b0, 5'd5},  // R5
        '{1'b0, 1'b1, 1'b1, 8'hEB, 24'h000030, 10'd3, 1'b0, 5'd6},  // R6
        '{1'b1, 1'b1, 1'b0, 8'h6B, 24'h000040, 10'd3, 1'b0, 5'd4},  // R4
        '{1'b0, 1'b1, 1'b0, 8'hEB, 24'hABCD80, 10'd3, 1'b1, 5'd7},  // R7 upper bits ignored
        '{1'b1, 1'b1, 1'b1, 8'hEB, 24'h000050, 10'd2, 1'b0, 5'd6}   // R6 four-line opcode
    };

    function automatic logic [7:0] exp_byte(input logic [23:0] a);
        logic [7:0] lo;
        lo = a[7:0];
        return (lo * 8'd29 + 8'd3) ^ a[15:8];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transaction; aborts half a byte early when half_extra is set.
    task automatic run_cmd(input logic qpi, input logic qe, input logic busy,
                           input logic [7:0] op, input logic [23:0] addr,
                           input int nbytes, input logic acc, input string tag,
                           input bit half_extra);
        logic [3:0] syms [24];
        int n = 0;
        bit early = 1'b0;
        logic [7:0] e;
        logic [AW-1:0] a;
        if (qpi) begin
            syms[n++] = op[7:4];
            syms[n++] = op[3:0];
        end else begin
            for (int i = 7; i >= 0; i--) syms[n++] = {3'b101, op[i]};
        end
        for (int i = 5; i >= 0; i--) syms[n++] = addr[i*4 +: 4];
        for (int i = 0; i < DMY; i++) syms[n++] = 4'h0;
        @(negedge sclk);
        qpi_mode = qpi; quad_en = qe; wr_busy = busy;
        cs_n = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (k > 0) @(negedge sclk);
            sio_i = syms[k];
            #1;
            if (sio_oe != 4'h0) early = 1'b1;
        end
        chk(!early, "R8 no drive before data", int'(early), 0);
        if (acc) begin
            a = addr[AW-1:0];
            for (int b = 0; b < nbytes; b++) begin
                e = exp_byte(24'(a));
                @(negedge sclk); #1;
                chk(sio_oe == 4'hF && sio_o == e[7:4], {tag, " R9 R10 R11 high nibble"},
                    {sio_oe, sio_o}, {4'hF, e[7:4]});
                @(negedge sclk); #1;
                chk(sio_oe == 4'hF && sio_o == e[3:0], {tag, " R9 R10 R11 low nibble"},
                    {sio_oe, sio_o}, {4'hF, e[3:0]});
                a = a + 1'b1;
            end
            if (half_extra) begin
                e = exp_byte(24'(a));
                @(negedge sclk); #1;
                chk(sio_o == e[7:4], "R12 nibble before abort", sio_o, e[7:4]);
            end
        end else begin
            early = 1'b0;
            for (int k = 0; k < 2 * nbytes + 2; k++) begin
                @(negedge sclk); #1;
                if (sio_oe != 4'h0) early = 1'b1;
            end
            chk(!early, {tag, " refused command stays undriven"}, int'(early), 0);
        end
        cs_n = 1'b1;
        #0.5;
        chk(sio_oe == 4'h0, "R12 R1 cs_n high disables outputs", sio_oe, 0);
        repeat (2) @(negedge sclk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: deselected state
        repeat (3) @(negedge sclk);
        #1;
        chk(sio_oe == 4'h0, "R1 reset oe", sio_oe, 0);

        for (int v = 0; v < NV; v++) begin
            run_cmd(VECS[v].qpi, VECS[v].qe, VECS[v].busy, VECS[v].op, VECS[v].addr,
                    int'(VECS[v].nbytes), VECS[v].acc, $sformatf("R%0d", VECS[v].tag), 1'b0);
        end

        // R11: stream past the top of the array and around again
        run_cmd(1'b0, 1'b1, 1'b0, 8'hEB, 24'h0000FF, 300, 1'b1, "R11 full sweep", 1'b0);
        // R12: abort mid-byte, then a fresh command must work (R1)
        run_cmd(1'b1, 1'b1, 1'b0, 8'hEB, 24'h000033, 1, 1'b1, "R12 abort", 1'b1);
        run_cmd(1'b0, 1'b1, 1'b0, 8'hEB, 24'h000077, 2, 1'b1, "R1 R12 after abort", 1'b0);
        // R4: wrong single-line opcode differing in one bit
        run_cmd(1'b0, 1'b1, 1'b0, 8'hEA, 24'h000010, 2, 1'b0, "R4 near-miss opcode", 1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule